// File: doc/BRIEF.md
# Framed Synchronous Serial Transmitter

This block turns parallel words into a serial bit stream on one data line. Each bit period is set by a bit clock, and word boundaries are marked with a frame-sync signal. The host hands words over through a valid/ready handshake and flags the final word of a block. A one-word holding register lets the next word wait while the current word is being shifted out.

Four configuration inputs select the behaviour:
- The bit clock comes either from an internal divider, modelled as a one-cycle enable pulse, or from an external clock line with a selectable active edge.
- The frame sync is either a short pulse that ends before the data starts (fixed rate) or a level held for the bits of the word (variable rate).
- Either every word is framed (standard), or only the first word of a block is framed and the rest follow with no gap (continuous).

With the internal clock the block drives the frame sync. With the external clock it samples an external sync instead.

Top module: `framed_tx`

## Requirements
- R1: After reset, `in_ready` is 1 and `fs_out`, `sdo`, `sdo_oe` and `underrun` are all 0.
- R2: `in_ready` is high exactly when the one-word holding register is empty. A word is taken only on a clock where `in_valid` and `in_ready` are both high. A word offered while `in_ready` is low has no effect on the transmitted stream.
- R3: Words go out most-significant bit first, one bit per bit period. `sdo` and `fs_out` change only on a bit-clock active edge.
- R4: With `cfg_int_clk`=1, each `bclk_en` pulse is one active edge, `fs_oe` is 1 and the block drives `fs_out`. With `cfg_int_clk`=0, active edges come from `bclk_ext` through a two-flop synchronizer, `fs_oe` is 0 and `fs_out` stays 0.
- R5: With the external clock, `cfg_clk_inv`=0 makes the rising edge of `bclk_ext` the active edge, and `cfg_clk_inv`=1 makes the falling edge active.
- R6: With the internal clock and fixed rate (`cfg_var_rate`=0), a framed word gets exactly one bit period with `fs_out`=1 and `sdo_oe`=0. The most-significant bit follows in the next period, with `fs_out`=0.
- R7: With the external clock and fixed rate, a word starts after `fs_in` has been seen high at an active edge. Its first bit is driven at the first later active edge where `fs_in` is low. A sync seen while no word is held is ignored.
- R8: In variable-rate mode (`cfg_var_rate`=1), a framed word starts at the active edge where the sync is present. With the internal clock, `fs_out` stays 1 for all of that word's bits. With the external clock, the word starts at the active edge where `fs_in` is high.
- R9: `sdo_oe` is 1 while a word is being shifted. With the external clock in variable-rate mode, `sdo_oe` is also 1 whenever `fs_in` is high. Otherwise `sdo_oe` is 0 and `sdo` is 0.
- R10: In standard mode (`cfg_cont`=0), every word is framed and is followed by one idle bit period. The last-word flag is ignored.
- R11: In continuous mode (`cfg_cont`=1), only the first word of a block is framed. Later words follow with no gap. One idle bit period follows the word flagged last.
- R12: In continuous mode, a non-last word may finish while no next word is held. The block then pulses `underrun` high for one clock and returns to idle. The next word starts a new, framed block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_int_clk | input | 1 | 1: internal bit clock and driven sync; 0: external |
| cfg_clk_inv | input | 1 | External bit clock active edge: 0 rising, 1 falling |
| cfg_var_rate | input | 1 | 0: fixed-rate sync pulse; 1: sync held through the bits |
| cfg_cont | input | 1 | 0: standard framing; 1: continuous blocks |
| bclk_en | input | 1 | Internal bit clock enable, one pulse per bit period |
| bclk_ext | input | 1 | External bit clock |
| fs_in | input | 1 | External frame sync |
| fs_out | output | 1 | Frame sync driven in internal-clock mode |
| fs_oe | output | 1 | Output enable for `fs_out` |
| sdo | output | 1 | Serial data |
| sdo_oe | output | 1 | Output enable for `sdo` |
| in_data | input | W | Word to transmit |
| in_last | input | 1 | Marks the final word of a block |
| in_valid | input | 1 | Host offers a word |
| in_ready | output | 1 | Holding register empty |
| underrun | output | 1 | One-clock pulse when a continuous block runs dry |

## Verification
The assertions assume that the configuration inputs change only while the block is idle with no frame sync active. They also assume that `fs_in` is stable around each active edge, and that `bclk_en` is used only in internal-clock mode. The stimulus follows these rules as follows:
- It changes the configuration between blocks, after the last idle period.
- It moves `fs_in` only while the bit clock is in its inactive phase, several cycles before the synchronized edge.
- It holds `bclk_ext` at its inactive level while the configuration settles.

// File: rtl/framed_tx.sv
module framed_tx #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cfg_int_clk,
  input  logic         cfg_clk_inv,
  input  logic         cfg_var_rate,
  input  logic         cfg_cont,
  input  logic         bclk_en,
  input  logic         bclk_ext,
  input  logic         fs_in,
  output logic         fs_out,
  output logic         fs_oe,
  output logic         sdo,
  output logic         sdo_oe,
  input  logic [W-1:0] in_data,
  input  logic         in_last,
  input  logic         in_valid,
  output logic         in_ready,
  output logic         underrun
);
  localparam int CW = (W > 2) ? $clog2(W) : 1;

  typedef enum logic [1:0] {IDLE, SYNC, WAITLO, SHIFT} st_t;

  st_t st, st_n;
  logic [2:0] bs;
  logic [W-1:0] hold_data, sh;
  logic hold_full, hold_last, sh_last;
  logic [CW-1:0] cnt;
  logic fs_q, fs_n, ur_n, load;

  wire rise = bs[1] & ~bs[2];
  wire fall = ~bs[1] & bs[2];
  wire tick = cfg_int_clk ? bclk_en : (cfg_clk_inv ? fall : rise);
  wire shifting = (st == SHIFT);
  wire more = cfg_cont & ~sh_last;

  assign in_ready = ~hold_full;
  assign fs_out   = fs_q;
  assign fs_oe    = cfg_int_clk;
  assign sdo      = shifting & sh[W-1];
  assign sdo_oe   = shifting | (~cfg_int_clk & cfg_var_rate & fs_in);

  always_comb begin
    st_n = st;
    fs_n = fs_q;
    ur_n = 1'b0;
    load = 1'b0;
    if (tick) begin
      unique case (st)
        IDLE:
          if (hold_full) begin
            if (cfg_int_clk) begin
              fs_n = 1'b1;
              if (cfg_var_rate) begin
                load = 1'b1;
                st_n = SHIFT;
              end else begin
                st_n = SYNC;
              end
            end else if (fs_in) begin
              if (cfg_var_rate) begin
                load = 1'b1;
                st_n = SHIFT;
              end else begin
                st_n = WAITLO;
              end
            end
          end
        SYNC: begin
          fs_n = 1'b0;
          load = 1'b1;
          st_n = SHIFT;
        end
        WAITLO:
          if (!fs_in) begin
            load = 1'b1;
            st_n = SHIFT;
          end
        SHIFT:
          if (cnt == '0) begin
            fs_n = 1'b0;
            if (more && hold_full) begin
              load = 1'b1;
            end else begin
              st_n = IDLE;
              ur_n = more;
            end
          end
        default: st_n = IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bs        <= '0;
      st        <= IDLE;
      fs_q      <= 1'b0;
      underrun  <= 1'b0;
      hold_full <= 1'b0;
      hold_last <= 1'b0;
      hold_data <= '0;
      sh        <= '0;
      sh_last   <= 1'b0;
      cnt       <= '0;
    end else begin
      bs       <= {bs[1:0], bclk_ext};
      st       <= st_n;
      fs_q     <= fs_n;
      underrun <= ur_n;
      if (load) begin
        hold_full <= 1'b0;
      end else if (in_valid && !hold_full) begin
        hold_full <= 1'b1;
        hold_data <= in_data;
        hold_last <= in_last;
      end
      if (load) begin
        sh      <= hold_data;
        sh_last <= hold_last;
        cnt     <= CW'(W - 1);
      end else if (tick && shifting && cnt != '0) begin
        sh  <= sh << 1;
        cnt <= cnt - 1'b1;
      end
    end
  end
endmodule

module framed_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic in_valid,
  input logic in_ready,
  input logic cfg_int_clk,
  input logic cfg_var_rate,
  input logic cfg_cont,
  input logic fs_out,
  input logic sdo,
  input logic sdo_oe,
  input logic underrun,
  input logic tick
);
  p_ready_fill_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> !in_ready);
  p_steady_between_edges_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(sdo) && $stable(fs_out));
  p_no_sync_drive_ext_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_int_clk |-> !fs_out);
  p_pulse_before_data_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_var_rate && fs_out |-> !sdo_oe);
  p_sync_covers_bits_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_var_rate && fs_out |-> sdo_oe);
  p_quiet_when_released_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !sdo_oe |-> !sdo);
  p_underrun_cont_r12: assert property (@(posedge clk) disable iff (!rst_n)
    underrun |-> cfg_cont);
  p_underrun_single_r12: assert property (@(posedge clk) disable iff (!rst_n)
    underrun |=> !underrun);
endmodule

bind framed_tx framed_tx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .cfg_int_clk(cfg_int_clk), .cfg_var_rate(cfg_var_rate), .cfg_cont(cfg_cont),
  .fs_out(fs_out), .sdo(sdo), .sdo_oe(sdo_oe), .underrun(underrun), .tick(tick)
);

// File: tb/framed_tx_test.sv
module framed_tx_test;
  localparam int W = 8;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_int_clk = 1'b0, cfg_clk_inv = 1'b0, cfg_var_rate = 1'b0, cfg_cont = 1'b0;
  logic bclk_en = 1'b0, bclk_ext = 1'b0, fs_in = 1'b0;
  logic [W-1:0] in_data = '0;
  logic in_last = 1'b0, in_valid = 1'b0;
  logic fs_out, fs_oe, sdo, sdo_oe, in_ready, underrun;

  always #(CLK_PERIOD/2) clk = ~clk;

  framed_tx #(.W(W)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_int_clk(cfg_int_clk), .cfg_clk_inv(cfg_clk_inv),
    .cfg_var_rate(cfg_var_rate), .cfg_cont(cfg_cont), .bclk_en(bclk_en),
    .bclk_ext(bclk_ext), .fs_in(fs_in), .fs_out(fs_out), .fs_oe(fs_oe), .sdo(sdo),
    .sdo_oe(sdo_oe), .in_data(in_data), .in_last(in_last), .in_valid(in_valid),
    .in_ready(in_ready), .underrun(underrun)
  );

  int checks = 0, errors = 0, ur_cnt = 0;
  logic [W-1:0] words [8];
  logic lasts [8];
  logic e_fs [128];
  logic e_oe [128];
  logic e_d  [128];
  int elen;

  always @(posedge clk) if (rst_n && underrun) ur_cnt++;

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic add(logic f, logic o, logic d);
    e_fs[elen] = f; e_oe[elen] = o; e_d[elen] = d; elen++;
  endtask

  task automatic build(int n, bit cont, bit vr);
    elen = 0;
    for (int i = 0; i < n; i++) begin
      bit first = (i == 0) || !cont;
      if (first && !vr) add(1'b1, 1'b0, 1'b0);
      for (int b = W - 1; b >= 0; b--) add(vr && first, 1'b1, words[i][b]);
      if (!cont || i == n - 1) add(1'b0, 1'b0, 1'b0);
    end
  endtask

  task automatic push_word(logic [W-1:0] d, logic l);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_data = d; in_last = l; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic run_periods(string tag);
    for (int p = 0; p < elen; p++) begin
      if (cfg_int_clk) begin
        bclk_en = 1'b1;
        @(negedge clk);
        bclk_en = 1'b0;
      end else begin
        fs_in = e_fs[p];
        bclk_ext = cfg_clk_inv;
        repeat (4) @(negedge clk);
        bclk_ext = !cfg_clk_inv;
        repeat (4) @(negedge clk);
      end
      check(tag, {fs_out, sdo_oe, sdo}, {cfg_int_clk ? e_fs[p] : 1'b0, e_oe[p], e_d[p]});
      if (cfg_int_clk) repeat (3) @(negedge clk);
    end
    fs_in = 1'b0;
  endtask

  task automatic set_cfg(bit cont, bit vr, bit ic, bit inv);
    cfg_cont = cont; cfg_var_rate = vr; cfg_int_clk = ic; cfg_clk_inv = inv;
    bclk_ext = inv;
    repeat (4) @(negedge clk);
  endtask

  task automatic run_block(int n, bit cont, bit vr, bit ic, bit inv, bit fin_last, bit junk);
    int ur0;
    string tag;
    set_cfg(cont, vr, ic, inv);
    for (int i = 0; i < n; i++) begin
      words[i] = W'($urandom);
      lasts[i] = cont ? ((i == n - 1) ? fin_last : 1'b0) : 1'($urandom_range(0, 1));
    end
    build(n, cont, vr);
    tag = $sformatf("%s %s %s R3 R9", vr ? "R8" : (ic ? "R6" : "R7"),
                    cont ? "R11" : "R10", ic ? "R4" : "R5");
    ur0 = ur_cnt;
    push_word(words[0], lasts[0]);
    check("R2 ready low when held", int'(in_ready), 0);
    check("R4 sync output enable", int'(fs_oe), int'(ic));
    if (junk) begin
      in_data = ~words[0]; in_last = 1'b1; in_valid = 1'b1;
      repeat (2) @(negedge clk);
      in_valid = 1'b0;
    end
    fork
      begin
        for (int i = 1; i < n; i++) push_word(words[i], lasts[i]);
      end
      run_periods(tag);
    join
    repeat (2) @(negedge clk);
    check("R12 underrun count", ur_cnt - ur0, (cont && !fin_last) ? 1 : 0);
    check("R2 ready after block", int'(in_ready), 1);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check("R1 in_ready", int'(in_ready), 1);
    check("R1 outputs", {fs_out, sdo, sdo_oe, underrun}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 after release", {fs_out, sdo, sdo_oe, underrun}, 0);

    for (int c = 0; c < 16; c++)
      run_block(3, c[0], c[1], c[2], c[3], 1'b1, c == 5);

    // R12: continuous block runs dry, then a fresh framed block
    run_block(2, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    run_block(1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0);
    run_block(3, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
    run_block(2, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0);

    // R9: external variable rate drives data line while sync is held, even idle
    set_cfg(1'b0, 1'b1, 1'b0, 1'b0);
    fs_in = 1'b1;
    repeat (2) @(negedge clk);
    check("R9 oe with sync held", int'(sdo_oe), 1);
    check("R9 idle data", int'(sdo), 0);
    fs_in = 1'b0;
    @(negedge clk);
    check("R9 released", int'(sdo_oe), 0);

    // R7: sync with nothing held is ignored
    set_cfg(1'b0, 1'b0, 1'b0, 1'b1);
    elen = 0;
    add(1'b1, 1'b0, 1'b0);
    add(1'b0, 1'b0, 1'b0);
    add(1'b0, 1'b0, 1'b0);
    run_periods("R7 empty sync ignored");
    run_block(2, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0);

    for (int k = 0; k < 24; k++)
      run_block($urandom_range(1, 5), 1'($urandom), 1'($urandom), 1'($urandom),
                1'($urandom), $urandom_range(0, 3) != 0, k % 7 == 3);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule